// File: doc/BRIEF.md
# Serial Controller Bus Register File

This block sits between a byte-wide processor bus and the datapath of a serial controller. It turns accesses in a 32-byte window into register loads, register reads and strobes. Only odd byte offsets are decoded. Several offsets are split by direction: a read returns a status or receive value, and a write at the same offset loads a different register. Two mode registers share one offset. A pointer inside the block chooses between them. The first access to mode register 1 moves the pointer to mode register 2. The pointer returns to mode register 1 after reset, or when the command decoder asserts `setPtrCmd`.

The output-port bits are never written directly. One offset sets the bits that are 1 in the data byte. Another offset clears them. A read of the receive offset pops the receive FIFO for one cycle, and a write of the transmit offset pushes into the transmit FIFO for one cycle. A write of the command offset is passed out unchanged to an external command decoder. Read data is combinational and is valid in the same cycle as the access.

Top module: `uart_reg_if`

## Requirements
- R1: After reset, every stored register and the output-port bits are zero, and the mode pointer selects mode register 1.
- R2: An access to offset 0x01 reaches mode register 1 when the pointer selects it, and mode register 2 otherwise. A read returns the register that was reached.
- R3: Any read or write of mode register 1 moves the pointer to mode register 2. Later accesses to 0x01 keep the pointer on mode register 2.
- R4: A cycle with `setPtrCmd` high returns the pointer to mode register 1. If an access to 0x01 happens in the same cycle, it uses the old pointer value and the command still takes effect.
- R5: Mode register 1 drives these fields: bit 7 receiver RTS control, bit 6 receiver interrupt select, bit 5 error mode, bits 4:3 parity mode, bit 2 parity type, bits 1:0 character length.
- R6: At 0x03, a read returns `statusIn` and a write loads the clock-select register. At 0x09, a read returns `ipChangeIn` and a write loads the auxiliary register. At 0x0B, a read returns `intStatusIn` and a write loads the interrupt mask.
- R7: A read of 0x07 returns `rxData` and raises `rxPop` for that cycle only. A write of 0x07 raises `txPush` for that cycle only, with `txData` equal to the written byte.
- R8: A write to 0x1D sets every output-port bit that is 1 in the data. A write to 0x1F clears every output-port bit that is 1 in the data. All other output-port bits keep their value. Reads of either offset return zero.
- R9: Reads of even offsets and of the reserved offsets return zero. Writes to them change no register, no output-port bit and no pointer. The reserved offsets are 0x11 to 0x17, 0x05 for reads and 0x1B for writes.
- R10: A write of 0x05 raises `cmdStrobe` for that cycle, with `cmdData` equal to the written byte.
- R11: Offsets 0x0D, 0x0F and 0x19 hold the prescale high byte, the prescale low byte and the vector register, and each reads back as written. A read of 0x1B returns `inputPortIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset in the window |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| setPtrCmd | input | 1 | Return the mode pointer to mode register 1 |
| statusIn | input | 8 | Status byte from the datapath |
| rxData | input | 8 | Head of the receive FIFO |
| ipChangeIn | input | 8 | Input-change byte |
| intStatusIn | input | 8 | Interrupt status byte |
| inputPortIn | input | 8 | Input pin levels |
| rxPop | output | 1 | Receive FIFO pop strobe |
| txPush | output | 1 | Transmit FIFO push strobe |
| txData | output | 8 | Transmit byte |
| cmdStrobe | output | 1 | Command write strobe |
| cmdData | output | 8 | Command byte |
| rxRtsCtl | output | 1 | Receiver RTS control |
| rxIrqSel | output | 1 | Receiver interrupt select |
| errMode | output | 1 | Error mode |
| parityMode | output | 2 | Parity mode |
| parityType | output | 1 | Parity type |
| charBits | output | 2 | Character length code |
| mode2Q | output | 8 | Mode register 2 |
| clkSelQ | output | 8 | Clock-select register |
| auxCtlQ | output | 8 | Auxiliary control register |
| intMaskQ | output | 8 | Interrupt mask |
| prescaleHiQ | output | 8 | Prescale high byte |
| prescaleLoQ | output | 8 | Prescale low byte |
| vectorQ | output | 8 | Vector register |
| outPort | output | 8 | Output-port bits |

## Verification
The bench follows the pointer through a full sequence: reset, a read of mode register 1, stays on mode register 2, a set-pointer command, and a set-pointer command in the same cycle as a mode access. A pointer that did not advance, or that advanced back to mode register 1, would return the wrong mode byte. The split offsets are written and then read back, so a decoder that stored the written byte in the readable register would return the written value instead of the datapath input. The set and clear writes overlap existing bits, which exposes a design that stores the data byte instead of modifying the bits. Writes to reserved and even offsets use all-ones data, so an access that leaked into a register would show up on its output.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int SLOT_W = ADDR_W - 1;

  // Mode register 1 field positions
  localparam int M1_RTS_BIT  = 7;
  localparam int M1_IRQ_BIT  = 6;
  localparam int M1_ERR_BIT  = 5;
  localparam int M1_PM_HI    = 4;
  localparam int M1_PM_LO    = 3;
  localparam int M1_PT_BIT   = 2;
  localparam int M1_CB_HI    = 1;
  localparam int M1_CB_LO    = 0;

  // Slot index = byte offset >> 1 (odd offsets only)
  typedef enum logic [3:0] {
    SLOT_MODE    = 4'd0,
    SLOT_STATCS  = 4'd1,
    SLOT_CMD     = 4'd2,
    SLOT_RXTX    = 4'd3,
    SLOT_IPCAUX  = 4'd4,
    SLOT_ISRIMR  = 4'd5,
    SLOT_BGHI    = 4'd6,
    SLOT_BGLO    = 4'd7,
    SLOT_RSV8    = 4'd8,
    SLOT_RSV9    = 4'd9,
    SLOT_RSV10   = 4'd10,
    SLOT_RSV11   = 4'd11,
    SLOT_VECTOR  = 4'd12,
    SLOT_INPORT  = 4'd13,
    SLOT_OPSET   = 4'd14,
    SLOT_OPCLR   = 4'd15
  } slotT;

  typedef enum logic [3:0] {
    RD_NONE   = 4'd0,
    RD_MODE1  = 4'd1,
    RD_MODE2  = 4'd2,
    RD_STATUS = 4'd3,
    RD_RXBUF  = 4'd4,
    RD_IPCHG  = 4'd5,
    RD_ISR    = 4'd6,
    RD_BGHI   = 4'd7,
    RD_BGLO   = 4'd8,
    RD_VECTOR = 4'd9,
    RD_INPORT = 4'd10
  } rdSelT;

  typedef struct packed {
    logic wrMode1;
    logic wrMode2;
    logic wrClkSel;
    logic wrCmd;
    logic wrTx;
    logic wrAux;
    logic wrMask;
    logic wrBgHi;
    logic wrBgLo;
    logic wrVector;
    logic wrOpSet;
    logic wrOpClr;
    logic popRx;
  } strobeT;

endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W_P-1:0] busAddr,
  input  logic                setPtrCmd,
  output strobeT              stb,
  output rdSelT               rdSel,
  output logic                modePtr
);

  localparam int SLOT_W_L = ADDR_W_P - 1;

  logic                oddHit;
  logic [SLOT_W_L-1:0] slotIdx;
  logic                modeHit;
  logic                isRd;
  logic                isWr;

  assign slotIdx = busAddr[ADDR_W_P-1:1];
  assign oddHit  = busSel && busAddr[0];
  assign isRd    = oddHit && !busWr;
  assign isWr    = oddHit && busWr;
  assign modeHit = oddHit && (slotIdx == SLOT_W_L'(SLOT_MODE));

  always_comb begin
    stb   = '0;
    rdSel = RD_NONE;
    if (oddHit) begin
      case (slotT'(slotIdx))
        SLOT_MODE: begin
          if (isWr) begin
            stb.wrMode1 = !modePtr;
            stb.wrMode2 = modePtr;
          end else begin
            rdSel = modePtr ? RD_MODE2 : RD_MODE1;
          end
        end
        SLOT_STATCS: begin
          if (isWr) stb.wrClkSel = 1'b1;
          else      rdSel = RD_STATUS;
        end
        SLOT_CMD: begin
          if (isWr) stb.wrCmd = 1'b1;
        end
        SLOT_RXTX: begin
          if (isWr) stb.wrTx = 1'b1;
          else begin
            stb.popRx = 1'b1;
            rdSel     = RD_RXBUF;
          end
        end
        SLOT_IPCAUX: begin
          if (isWr) stb.wrAux = 1'b1;
          else      rdSel = RD_IPCHG;
        end
        SLOT_ISRIMR: begin
          if (isWr) stb.wrMask = 1'b1;
          else      rdSel = RD_ISR;
        end
        SLOT_BGHI: begin
          if (isWr) stb.wrBgHi = 1'b1;
          else      rdSel = RD_BGHI;
        end
        SLOT_BGLO: begin
          if (isWr) stb.wrBgLo = 1'b1;
          else      rdSel = RD_BGLO;
        end
        SLOT_VECTOR: begin
          if (isWr) stb.wrVector = 1'b1;
          else      rdSel = RD_VECTOR;
        end
        SLOT_INPORT: begin
          if (isRd) rdSel = RD_INPORT;
        end
        SLOT_OPSET: begin
          if (isWr) stb.wrOpSet = 1'b1;
        end
        SLOT_OPCLR: begin
          if (isWr) stb.wrOpClr = 1'b1;
        end
        default: begin
          stb   = '0;
          rdSel = RD_NONE;
        end
      endcase
    end
  end

  // Mode pointer: 0 selects mode register 1, 1 selects mode register 2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          modePtr <= 1'b0;
    else if (setPtrCmd) modePtr <= 1'b0;
    else if (modeHit)   modePtr <= 1'b1;
  end

  AST_PTR_SETCMD: assert property (@(posedge clk) disable iff (!rstN) setPtrCmd |=> !modePtr); // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN) (modeHit && !setPtrCmd) |=> modePtr); // R3
  AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rstN) (modePtr && !setPtrCmd) |=> modePtr); // R3
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(stb)); // R7
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rstN) (busSel && busWr) |-> (rdSel == RD_NONE)); // R6

endmodule

// File: rtl/uart_reg_dp.sv
module uart_reg_dp
  import uart_reg_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  rdSelT               rdSel,
  input  logic [DATA_W_P-1:0] wdata,
  input  logic [DATA_W_P-1:0] statusIn,
  input  logic [DATA_W_P-1:0] rxData,
  input  logic [DATA_W_P-1:0] ipChangeIn,
  input  logic [DATA_W_P-1:0] intStatusIn,
  input  logic [DATA_W_P-1:0] inputPortIn,
  output logic [DATA_W_P-1:0] rdata,
  output logic [DATA_W_P-1:0] mode1Q,
  output logic [DATA_W_P-1:0] mode2Q,
  output logic [DATA_W_P-1:0] clkSelQ,
  output logic [DATA_W_P-1:0] auxCtlQ,
  output logic [DATA_W_P-1:0] intMaskQ,
  output logic [DATA_W_P-1:0] prescaleHiQ,
  output logic [DATA_W_P-1:0] prescaleLoQ,
  output logic [DATA_W_P-1:0] vectorQ,
  output logic [DATA_W_P-1:0] outPort
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode1Q      <= '0;
      mode2Q      <= '0;
      clkSelQ     <= '0;
      auxCtlQ     <= '0;
      intMaskQ    <= '0;
      prescaleHiQ <= '0;
      prescaleLoQ <= '0;
      vectorQ     <= '0;
    end else begin
      if (stb.wrMode1)  mode1Q      <= wdata;
      if (stb.wrMode2)  mode2Q      <= wdata;
      if (stb.wrClkSel) clkSelQ     <= wdata;
      if (stb.wrAux)    auxCtlQ     <= wdata;
      if (stb.wrMask)   intMaskQ    <= wdata;
      if (stb.wrBgHi)   prescaleHiQ <= wdata;
      if (stb.wrBgLo)   prescaleLoQ <= wdata;
      if (stb.wrVector) vectorQ     <= wdata;
    end
  end

  for (genvar b = 0; b < DATA_W_P; b++) begin : gOutBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          outPort[b] <= 1'b0;
      else if (stb.wrOpSet && wdata[b])   outPort[b] <= 1'b1;
      else if (stb.wrOpClr && wdata[b])   outPort[b] <= 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      RD_MODE1:  rdata = mode1Q;
      RD_MODE2:  rdata = mode2Q;
      RD_STATUS: rdata = statusIn;
      RD_RXBUF:  rdata = rxData;
      RD_IPCHG:  rdata = ipChangeIn;
      RD_ISR:    rdata = intStatusIn;
      RD_BGHI:   rdata = prescaleHiQ;
      RD_BGLO:   rdata = prescaleLoQ;
      RD_VECTOR: rdata = vectorQ;
      RD_INPORT: rdata = inputPortIn;
      default:   rdata = '0;
    endcase
  end

  AST_OPSET_BITS: assert property (@(posedge clk) disable iff (!rstN) stb.wrOpSet |=> ((outPort & $past(wdata)) == $past(wdata))); // R8
  AST_OPCLR_BITS: assert property (@(posedge clk) disable iff (!rstN) stb.wrOpClr |=> ((outPort & $past(wdata)) == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (stb == '0) |=> ($stable(mode1Q) && $stable(mode2Q) && $stable(clkSelQ) && $stable(auxCtlQ) && $stable(intMaskQ) && $stable(outPort))); // R9

endmodule

// File: rtl/uart_reg_if.sv
module uart_reg_if
  import uart_reg_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W_P-1:0] busAddr,
  input  logic [DATA_W_P-1:0] busWdata,
  output logic [DATA_W_P-1:0] busRdata,
  input  logic                setPtrCmd,
  input  logic [DATA_W_P-1:0] statusIn,
  input  logic [DATA_W_P-1:0] rxData,
  input  logic [DATA_W_P-1:0] ipChangeIn,
  input  logic [DATA_W_P-1:0] intStatusIn,
  input  logic [DATA_W_P-1:0] inputPortIn,
  output logic                rxPop,
  output logic                txPush,
  output logic [DATA_W_P-1:0] txData,
  output logic                cmdStrobe,
  output logic [DATA_W_P-1:0] cmdData,
  output logic                rxRtsCtl,
  output logic                rxIrqSel,
  output logic                errMode,
  output logic [1:0]          parityMode,
  output logic                parityType,
  output logic [1:0]          charBits,
  output logic [DATA_W_P-1:0] mode2Q,
  output logic [DATA_W_P-1:0] clkSelQ,
  output logic [DATA_W_P-1:0] auxCtlQ,
  output logic [DATA_W_P-1:0] intMaskQ,
  output logic [DATA_W_P-1:0] prescaleHiQ,
  output logic [DATA_W_P-1:0] prescaleLoQ,
  output logic [DATA_W_P-1:0] vectorQ,
  output logic [DATA_W_P-1:0] outPort
);

  strobeT              stb;
  rdSelT               rdSel;
  logic                modePtr;
  logic [DATA_W_P-1:0] mode1Q;

  uart_reg_ctrl #(.ADDR_W_P(ADDR_W_P)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .setPtrCmd (setPtrCmd),
    .stb       (stb),
    .rdSel     (rdSel),
    .modePtr   (modePtr)
  );

  uart_reg_dp #(.DATA_W_P(DATA_W_P)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .rdSel       (rdSel),
    .wdata       (busWdata),
    .statusIn    (statusIn),
    .rxData      (rxData),
    .ipChangeIn  (ipChangeIn),
    .intStatusIn (intStatusIn),
    .inputPortIn (inputPortIn),
    .rdata       (busRdata),
    .mode1Q      (mode1Q),
    .mode2Q      (mode2Q),
    .clkSelQ     (clkSelQ),
    .auxCtlQ     (auxCtlQ),
    .intMaskQ    (intMaskQ),
    .prescaleHiQ (prescaleHiQ),
    .prescaleLoQ (prescaleLoQ),
    .vectorQ     (vectorQ),
    .outPort     (outPort)
  );

  assign rxPop      = stb.popRx;
  assign txPush     = stb.wrTx;
  assign txData     = busWdata;
  assign cmdStrobe  = stb.wrCmd;
  assign cmdData    = busWdata;
  assign rxRtsCtl   = mode1Q[M1_RTS_BIT];
  assign rxIrqSel   = mode1Q[M1_IRQ_BIT];
  assign errMode    = mode1Q[M1_ERR_BIT];
  assign parityMode = mode1Q[M1_PM_HI:M1_PM_LO];
  assign parityType = mode1Q[M1_PT_BIT];
  assign charBits   = mode1Q[M1_CB_HI:M1_CB_LO];

endmodule

// File: tb/tb_uart_reg_if.sv
module tb_uart_reg_if;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       setPtrCmd = 1'b0;
  logic [7:0] statusIn = 8'h5A;
  logic [7:0] rxData = 8'hE1;
  logic [7:0] ipChangeIn = 8'hC3;
  logic [7:0] intStatusIn = 8'h96;
  logic [7:0] inputPortIn = 8'h6D;
  logic       rxPop, txPush, cmdStrobe;
  logic [7:0] txData, cmdData;
  logic       rxRtsCtl, rxIrqSel, errMode, parityType;
  logic [1:0] parityMode, charBits;
  logic [7:0] mode2Q, clkSelQ, auxCtlQ, intMaskQ, prescaleHiQ, prescaleLoQ, vectorQ, outPort;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  uart_reg_if dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .setPtrCmd(setPtrCmd),
    .statusIn(statusIn), .rxData(rxData), .ipChangeIn(ipChangeIn),
    .intStatusIn(intStatusIn), .inputPortIn(inputPortIn),
    .rxPop(rxPop), .txPush(txPush), .txData(txData),
    .cmdStrobe(cmdStrobe), .cmdData(cmdData),
    .rxRtsCtl(rxRtsCtl), .rxIrqSel(rxIrqSel), .errMode(errMode),
    .parityMode(parityMode), .parityType(parityType), .charBits(charBits),
    .mode2Q(mode2Q), .clkSelQ(clkSelQ), .auxCtlQ(auxCtlQ), .intMaskQ(intMaskQ),
    .prescaleHiQ(prescaleHiQ), .prescaleLoQ(prescaleLoQ), .vectorQ(vectorQ),
    .outPort(outPort)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (busSel && !busWr && expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata, e, t);
      end
    end
  end

  task automatic startAcc(input logic wr, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d;
  endtask

  task automatic endAcc();
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; setPtrCmd = 1'b0;
    #2;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    startAcc(1'b0, a, 8'h00);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    endAcc();
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    startAcc(1'b1, a, d);
    endAcc();
  endtask

  task automatic ptrCmd();
    @(negedge clk);
    setPtrCmd = 1'b1;
    @(negedge clk);
    setPtrCmd = 1'b0;
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    check(outPort, 8'h00, "R1 outPort");
    check(clkSelQ, 8'h00, "R1 clkSel");
    check(mode2Q, 8'h00, "R1 mode2");
    check({rxRtsCtl, rxIrqSel, errMode, parityMode, parityType, charBits}, 8'h00, "R1 mode1 fields");
    wr(5'h01, 8'hA5);            // pointer at mode1 after reset (R1)
    check({rxRtsCtl, rxIrqSel, errMode, parityMode, parityType, charBits}, 8'hA5, "R1 pointer at mode1");
    // R5 fields of 0xA5 = 1_0_1_00_1_01
    check({7'd0, rxRtsCtl}, 8'h01, "R5 rts");
    check({7'd0, rxIrqSel}, 8'h00, "R5 irq");
    check({7'd0, errMode}, 8'h01, "R5 err");
    check({6'd0, parityMode}, 8'h00, "R5 parity mode");
    check({7'd0, parityType}, 8'h01, "R5 parity type");
    check({6'd0, charBits}, 8'h01, "R5 char bits");
    // R3 pointer advanced to mode2
    wr(5'h01, 8'h3C);
    check(mode2Q, 8'h3C, "R3 write reached mode2");
    rd(5'h01, 8'h3C, "R3 sticky read 1");
    rd(5'h01, 8'h3C, "R3 sticky read 2");
    // R2 / R4 set pointer
    ptrCmd();
    rd(5'h01, 8'hA5, "R2 read mode1 after set pointer");
    rd(5'h01, 8'h3C, "R3 read of mode1 advances");
    // R4 set pointer together with mode access (uses old pointer)
    startAcc(1'b1, 5'h01, 8'h77);
    setPtrCmd = 1'b1;
    endAcc();
    check(mode2Q, 8'h77, "R4 simultaneous write hit mode2");
    rd(5'h01, 8'hA5, "R4 pointer back at mode1");
    // R6 split offsets
    rd(5'h03, 8'h5A, "R6 status read");
    wr(5'h03, 8'h99);
    check(clkSelQ, 8'h99, "R6 clock select write");
    rd(5'h03, 8'h5A, "R6 status not clksel");
    wr(5'h09, 8'h81);
    check(auxCtlQ, 8'h81, "R6 aux write");
    rd(5'h09, 8'hC3, "R6 input change read");
    wr(5'h0B, 8'h24);
    check(intMaskQ, 8'h24, "R6 mask write");
    rd(5'h0B, 8'h96, "R6 isr read");
    // R7 receive pop and transmit push
    startAcc(1'b0, 5'h07, 8'h00);
    expQ.push_back(8'hE1); tagQ.push_back("R7 rx data");
    #2;
    check({7'd0, rxPop}, 8'h01, "R7 pop during read");
    check({7'd0, txPush}, 8'h00, "R7 no push on read");
    endAcc();
    check({7'd0, rxPop}, 8'h00, "R7 pop one cycle");
    startAcc(1'b1, 5'h07, 8'h42);
    #2;
    check({7'd0, txPush}, 8'h01, "R7 push during write");
    check(txData, 8'h42, "R7 tx data");
    check({7'd0, rxPop}, 8'h00, "R7 no pop on write");
    endAcc();
    check({7'd0, txPush}, 8'h00, "R7 push one cycle");
    // R8 output port set / clear
    wr(5'h1D, 8'h0F);
    check(outPort, 8'h0F, "R8 set first");
    wr(5'h1D, 8'h30);
    check(outPort, 8'h3F, "R8 set keeps others");
    wr(5'h1F, 8'h05);
    check(outPort, 8'h3A, "R8 clear selected bits");
    rd(5'h1D, 8'h00, "R8 set address reads zero");
    rd(5'h1F, 8'h00, "R8 clear address reads zero");
    // R10 command pass-through
    startAcc(1'b1, 5'h05, 8'h4B);
    #2;
    check({7'd0, cmdStrobe}, 8'h01, "R10 cmd strobe");
    check(cmdData, 8'h4B, "R10 cmd data");
    endAcc();
    check({7'd0, cmdStrobe}, 8'h00, "R10 cmd strobe one cycle");
    // R11 plain registers
    wr(5'h0D, 8'h12);
    wr(5'h0F, 8'h34);
    wr(5'h19, 8'h0F);
    rd(5'h0D, 8'h12, "R11 prescale hi");
    rd(5'h0F, 8'h34, "R11 prescale lo");
    rd(5'h19, 8'h0F, "R11 vector");
    rd(5'h1B, 8'h6D, "R11 input port");
    // R9 reserved and even offsets
    wr(5'h11, 8'hFF);
    wr(5'h17, 8'hFF);
    wr(5'h1B, 8'hFF);
    wr(5'h02, 8'hFF);
    wr(5'h1C, 8'hFF);
    check(outPort, 8'h3A, "R9 outPort unchanged");
    check(clkSelQ, 8'h99, "R9 clksel unchanged");
    check(auxCtlQ, 8'h81, "R9 aux unchanged");
    check(vectorQ, 8'h0F, "R9 vector unchanged");
    check(mode2Q, 8'h77, "R9 mode2 unchanged");
    rd(5'h05, 8'h00, "R9 cmd offset reads zero");
    rd(5'h13, 8'h00, "R9 reserved reads zero");
    rd(5'h06, 8'h00, "R9 even offset reads zero");
    rd(5'h01, 8'h77, "R9 pointer not moved by reserved");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule